// File: doc/BRIEF.md
# Utopia Transmit Cell Mover

This block moves ATM cells from a small 9-bit interface FIFO, which an upstream bus-transfer engine fills, onto the transmit side of a Utopia level 2 physical-layer device. The Utopia side runs on a slow clock that the block derives from its system clock by a fixed divide ratio (by default 16). It can therefore sit next to a fast bus engine and still pace the PHY at one byte per Utopia clock.

The block keeps sampling the PHY's cell-available line. When that line reports room for a cell, it raises a ready line to the upstream engine. The engine then writes the cell's bytes into the interface FIFO, with bit 8 of the first entry set to mark the start of the cell. The block waits until the FIFO reports full. It then sends the cell, one entry per Utopia clock, with transmit enable active low and start-of-cell taken from bit 8. After 53 bytes it releases the bus and goes back to polling. If the FIFO runs dry in the middle of a cell, the block idles the bus for those Utopia cycles and raises an underrun flag.

Top module: `utx_cell_mover`

## Requirements
- R1: Synchronous reset sets tx_enb_n=1, tx_soc=0, cell_ready=0, underrun=0 and wr_full=0.
- R2: cell_ready rises only after tx_clav has been sampled as 1 at a Utopia tick. While tx_clav stays 0, cell_ready stays 0. With tx_clav held at 1, cell_ready is high within DIV+1 clk cycles.
- R3: tx_clk has a period of DIV clk cycles. tx_enb_n, tx_soc and tx_data change only on the clk edge where the divider wraps, which is DIV/2 clk cycles after a rising edge of tx_clk. The PHY therefore samples stable values on each rising edge.
- R4: After a cell has been offered, tx_enb_n stays 1 until the interface FIFO reports full, even if it already holds data.
- R5: Each transfer puts entry bits 7:0 on tx_data and entry bit 8 on tx_soc. Entries leave in the order they were written, and tx_soc=1 appears only on the first byte of a cell.
- R6: Each cell has exactly CELL_BYTES (53) enabled transfers. tx_enb_n then returns to 1, and polling resumes, so cell_ready can rise again.
- R7: cell_ready falls on the clk edge that accepts the first FIFO write of a cell. It stays 0 until that cell has been sent.
- R8: If the FIFO is empty at a Utopia tick inside a cell, tx_enb_n is 1 for that Utopia cycle and underrun becomes 1. The cell then resumes where it stopped. underrun stays 1 until the next cell starts to transmit, and is cleared at that point.
- R9: The interface FIFO holds DEPTH entries. wr_full=1 when it holds DEPTH entries, and a write while wr_full=1 is dropped and never reaches tx_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Upstream write strobe into the interface FIFO |
| wr_data | input | 9 | Entry: bit 8 start-of-cell, bits 7:0 byte |
| wr_full | output | 1 | Interface FIFO full |
| cell_ready | output | 1 | PHY has room; upstream may start a cell |
| tx_clav | input | 1 | PHY cell-available (room) indication |
| tx_clk | output | 1 | Derived Utopia transmit clock |
| tx_enb_n | output | 1 | Transmit enable, active low |
| tx_soc | output | 1 | Start-of-cell marker |
| tx_data | output | 8 | Transmit byte |
| underrun | output | 1 | FIFO ran empty inside a cell |

## Verification
Every Utopia-side result appears on the clk edge where the divider wraps, DIV/2 cycles after a rising edge of tx_clk. The bench therefore captures tx_enb_n, tx_soc and tx_data in a PHY model at each rising edge of tx_clk. A phase monitor confirms that every change of tx_enb_n is seen exactly DIV/2 clk cycles after that rising edge. cell_ready is due one clk edge after a tick that samples tx_clav=1, and falls on the edge that accepts the first write. The bench waits up to DIV+1 cycles for the rise and samples one negative edge after the write for the fall. Cell contents, idle cycles inside a cell and the underrun flag are compared only after tx_enb_n has stayed high for two Utopia periods following the last byte.

// File: rtl/utx_pkg.sv
package utx_pkg;
  typedef enum logic [1:0] {
    ST_POLL,   // waiting for the PHY to report room
    ST_READY,  // offering a cell slot upstream
    ST_FILL,   // first entry accepted, waiting for FIFO full
    ST_SEND    // moving entries onto the Utopia bus
  } utx_state_t;
endpackage

// File: rtl/utx_tick_gen.sv
module utx_tick_gen #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst,
  output logic tick,
  output logic uclk
);
  localparam int unsigned CW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int unsigned HALF = DIV / 2;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nx;

  // tick marks the last cycle of a Utopia period; outputs update at its edge
  assign tick = (cnt_q == CW'(DIV - 1));

  always_comb begin
    if (tick) cnt_nx = '0;
    else      cnt_nx = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      uclk  <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      uclk  <= (cnt_nx >= CW'(HALF));
    end
  end
endmodule

// File: rtl/utx_ififo.sv
module utx_ififo #(
  parameter int unsigned W     = 9,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         wr_ok,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          rd_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign wr_ok   = wr_en & ~full;
  assign rd_ok   = rd_en & ~empty;
  assign rd_data = mem[rp_q];

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  // storage without reset so the array maps to distributed or block RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wp_q <= ptr_inc(wp_q);
      if (rd_ok) rp_q <= ptr_inc(rp_q);
      case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/utx_ctrl.sv
module utx_ctrl
  import utx_pkg::*;
#(
  parameter int unsigned DW         = 8,
  parameter int unsigned CELL_BYTES = 53
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        clav,
  input  logic        wr_ok,
  input  logic        fifo_full,
  input  logic        fifo_empty,
  input  logic [DW:0] rd_data,
  output logic        rd_en,
  output logic        cell_ready,
  output logic        tx_enb_n,
  output logic        tx_soc,
  output logic [DW-1:0] tx_data,
  output logic        underrun
);
  localparam int unsigned BW = $clog2(CELL_BYTES + 1);

  utx_state_t    st_q, st_nx;
  logic [BW-1:0] bcnt_q;
  logic          start_cell;
  logic          last_byte;
  logic          starved;

  assign start_cell = tick & (st_q == ST_FILL) & fifo_full;
  assign starved    = tick & (st_q == ST_SEND) & fifo_empty;
  assign rd_en      = start_cell | (tick & (st_q == ST_SEND) & ~fifo_empty);
  assign last_byte  = rd_en & (bcnt_q == BW'(CELL_BYTES - 1));
  assign cell_ready = (st_q == ST_READY);

  always_comb begin
    st_nx = st_q;
    case (st_q)
      ST_POLL:  if (tick && clav) st_nx = ST_READY;
      ST_READY: if (wr_ok)        st_nx = ST_FILL;
      ST_FILL:  if (start_cell)   st_nx = last_byte ? ST_POLL : ST_SEND;
      ST_SEND:  if (last_byte)    st_nx = ST_POLL;
      default:                    st_nx = ST_POLL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_POLL;
      bcnt_q   <= '0;
      tx_enb_n <= 1'b1;
      tx_soc   <= 1'b0;
      tx_data  <= '0;
      underrun <= 1'b0;
    end else begin
      st_q <= st_nx;
      if (rd_en) bcnt_q <= last_byte ? '0 : bcnt_q + 1'b1;
      if (tick) begin
        if (rd_en) begin
          tx_enb_n <= 1'b0;
          tx_soc   <= rd_data[DW];
          tx_data  <= rd_data[DW-1:0];
        end else begin
          tx_enb_n <= 1'b1;
          tx_soc   <= 1'b0;
        end
      end
      if (start_cell)   underrun <= 1'b0;
      else if (starved) underrun <= 1'b1;
    end
  end
endmodule

// File: rtl/utx_cell_mover.sv
module utx_cell_mover #(
  parameter int unsigned DIV        = 16,
  parameter int unsigned DEPTH      = 2,
  parameter int unsigned CELL_BYTES = 53,
  parameter int unsigned DW         = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW:0]   wr_data,
  output logic          wr_full,
  output logic          cell_ready,
  input  logic          tx_clav,
  output logic          tx_clk,
  output logic          tx_enb_n,
  output logic          tx_soc,
  output logic [DW-1:0] tx_data,
  output logic          underrun
);
  localparam int unsigned EW = DW + 1;

  logic          tick_w;
  logic          wr_ok_w;
  logic          rd_en_w;
  logic          empty_w;
  logic [EW-1:0] rd_data_w;

  utx_tick_gen #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick_w),
    .uclk (tx_clk)
  );

  utx_ififo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .wr_ok   (wr_ok_w),
    .rd_en   (rd_en_w),
    .rd_data (rd_data_w),
    .full    (wr_full),
    .empty   (empty_w)
  );

  utx_ctrl #(.DW(DW), .CELL_BYTES(CELL_BYTES)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick_w),
    .clav       (tx_clav),
    .wr_ok      (wr_ok_w),
    .fifo_full  (wr_full),
    .fifo_empty (empty_w),
    .rd_data    (rd_data_w),
    .rd_en      (rd_en_w),
    .cell_ready (cell_ready),
    .tx_enb_n   (tx_enb_n),
    .tx_soc     (tx_soc),
    .tx_data    (tx_data),
    .underrun   (underrun)
  );
endmodule

// File: rtl/utx_checker.sv
module utx_checker #(
  parameter int unsigned CELL_BYTES = 53,
  parameter int unsigned DW         = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          tx_clav,
  input logic          cell_ready,
  input logic          tx_enb_n,
  input logic          tx_soc,
  input logic [DW-1:0] tx_data,
  input logic          underrun,
  input logic          wr_en,
  input logic          wr_full
);
  localparam int unsigned XW = $clog2(CELL_BYTES + 2);

  logic          tick_d;
  logic [XW-1:0] xfer_cnt;

  // counts enabled transfers since the last start-of-cell
  always_ff @(posedge clk) begin
    if (rst) begin
      tick_d   <= 1'b0;
      xfer_cnt <= '0;
    end else begin
      tick_d <= tick;
      if (tick_d && !tx_enb_n) begin
        if (tx_soc) xfer_cnt <= XW'(1);
        else if (xfer_cnt <= XW'(CELL_BYTES)) xfer_cnt <= xfer_cnt + 1'b1;
      end
    end
  end

  a_r2_ready_after_clav: assert property (@(posedge clk) disable iff (rst)
    $rose(cell_ready) |-> $past(tx_clav));

  a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(tx_enb_n) && $stable(tx_soc) && $stable(tx_data)));

  a_r5_soc_needs_enable: assert property (@(posedge clk) disable iff (rst)
    tx_soc |-> !tx_enb_n);

  a_r6_cell_length: assert property (@(posedge clk) disable iff (rst)
    xfer_cnt <= XW'(CELL_BYTES));

  a_r7_ready_quiet_in_flight: assert property (@(posedge clk) disable iff (rst)
    !tx_enb_n |-> !cell_ready);

  a_r8_underrun_idles_bus: assert property (@(posedge clk) disable iff (rst)
    $rose(underrun) |-> tx_enb_n);

  a_r9_full_holds: assert property (@(posedge clk) disable iff (rst)
    (wr_full && wr_en && !tick) |=> wr_full);
endmodule

bind utx_cell_mover utx_checker #(.CELL_BYTES(CELL_BYTES), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick_w),
  .tx_clav    (tx_clav),
  .cell_ready (cell_ready),
  .tx_enb_n   (tx_enb_n),
  .tx_soc     (tx_soc),
  .tx_data    (tx_data),
  .underrun   (underrun),
  .wr_en      (wr_en),
  .wr_full    (wr_full)
);

// File: tb/sim_utx_cell_mover.sv
`timescale 1ns/1ps
module sim_utx_cell_mover;
  localparam int DIV  = 16;
  localparam int CELL = 53;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic       wr_full, cell_ready, tx_clk, tx_enb_n, tx_soc, underrun;
  logic       tx_clav = 1'b0;
  logic [7:0] tx_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  utx_cell_mover #(.DIV(DIV), .DEPTH(2), .CELL_BYTES(CELL), .DW(8)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
    .cell_ready(cell_ready), .tx_clav(tx_clav), .tx_clk(tx_clk),
    .tx_enb_n(tx_enb_n), .tx_soc(tx_soc), .tx_data(tx_data), .underrun(underrun)
  );

  // PHY model: capture on each rising edge of the Utopia clock
  logic [8:0] cap [0:511];
  int cap_n    = 0;
  int idle_mid = 0;
  always @(posedge tx_clk) begin
    if (!rst) begin
      if (!tx_enb_n) begin
        cap[cap_n] <= {tx_soc, tx_data};
        cap_n      <= cap_n + 1;
      end else if (cap_n % CELL != 0) begin
        idle_mid <= idle_mid + 1;
      end
    end
  end

  // phase monitor for R3 and in-flight ready monitor for R7
  int   ph = 0, last_period = 0, phase_bad = 0, ready_bad = 0;
  logic uclk_prev = 1'b0, enb_prev = 1'b1;
  always @(negedge clk) begin
    if (!rst) begin
      if (tx_clk && !uclk_prev) begin
        last_period = ph + 1;
        ph = 0;
      end else begin
        ph = ph + 1;
      end
      uclk_prev = tx_clk;
      if (tx_enb_n !== enb_prev && ph != DIV / 2) phase_bad = phase_bad + 1;
      enb_prev = tx_enb_n;
      if (!tx_enb_n && cell_ready) ready_bad = ready_bad + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [8:0] e);
    @(negedge clk);
    while (wr_full) @(negedge clk);
    wr_en = 1'b1; wr_data = e;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [8:0] ent(input int base, input int i);
    return {(i == 0), 8'(base + i)};
  endfunction

  task automatic wait_ready();
    @(negedge clk);
    while (!cell_ready) @(negedge clk);
  endtask

  task automatic wait_cell_end(input int start);
    while (cap_n < start + CELL) @(negedge clk);
    repeat (2 * DIV) @(negedge clk);
  endtask

  task automatic cmp_cell(input string req, input int start, input int base);
    int bad = 0;
    for (int i = 0; i < CELL; i++) if (cap[start + i] !== ent(base, i)) bad++;
    chk(req, bad, 0);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 enb_n", int'(tx_enb_n), 1);
    chk("R1 soc", int'(tx_soc), 0);
    chk("R1 ready", int'(cell_ready), 0);
    chk("R1 underrun", int'(underrun), 0);
    chk("R1 full", int'(wr_full), 0);
  endtask

  task automatic t_clav();
    int waited = 0;
    int rose = 0;
    repeat (6 * DIV) begin
      @(negedge clk);
      if (cell_ready) rose = 1;
    end
    chk("R2 no ready without clav", rose, 0);
    tx_clav = 1'b1;
    @(negedge clk);
    while (!cell_ready && waited < 4 * DIV) begin @(negedge clk); waited++; end
    chk("R2 ready within a tick", int'(waited <= DIV + 1), 1);
  endtask

  task automatic t_hold_until_full();
    int start;
    wait_ready();
    start = cap_n;
    put(ent(16, 0));
    chk("R7 ready drops at first write", int'(cell_ready), 0);
    repeat (5 * DIV) @(negedge clk);
    chk("R4 no enable before full", int'(tx_enb_n), 1);
    chk("R4 nothing sent before full", cap_n - start, 0);
    for (int i = 1; i < CELL; i++) put(ent(16, i));
    wait_cell_end(start);
    cmp_cell("R5 content and soc", start, 16);
    chk("R6 exactly one cell", cap_n - start, CELL);
    chk("R6 enable released", int'(tx_enb_n), 1);
    chk("R8 no underrun on steady cell", int'(underrun), 0);
  endtask

  task automatic t_full_drop();
    int start;
    wait_ready();
    start = cap_n;
    @(posedge tx_clk);
    put(ent(96, 0));
    put(ent(96, 1));
    chk("R9 full at depth", int'(wr_full), 1);
    wr_en = 1'b1; wr_data = 9'h0EE;
    @(negedge clk);
    wr_en = 1'b0;
    for (int i = 2; i < CELL; i++) put(ent(96, i));
    wait_cell_end(start);
    cmp_cell("R9 dropped write absent", start, 96);
    chk("R6 second cell length", cap_n - start, CELL);
  endtask

  task automatic t_underrun();
    int start, idle0;
    wait_ready();
    start = cap_n;
    idle0 = idle_mid;
    for (int i = 0; i < CELL; i++) begin
      if (i == 20) repeat (12 * DIV) @(negedge clk);
      put(ent(160, i));
    end
    wait_cell_end(start);
    cmp_cell("R8 cell resumes intact", start, 160);
    chk("R8 underrun raised", int'(underrun), 1);
    chk("R8 bus idled mid cell", int'(idle_mid - idle0 > 0), 1);
    chk("R6 underrun cell length", cap_n - start, CELL);
  endtask

  task automatic t_clean_after();
    int start;
    wait_ready();
    start = cap_n;
    for (int i = 0; i < CELL; i++) put(ent(32, i));
    wait_cell_end(start);
    cmp_cell("R5 back-to-back content", start, 32);
    chk("R8 underrun cleared by next cell", int'(underrun), 0);
    chk("R3 tx_clk period", last_period, DIV);
    chk("R3 updates half a period after rise", phase_bad, 0);
    chk("R7 ready quiet while enabled", ready_bad, 0);
  endtask

  initial begin
    t_reset();
    t_clav();
    t_hold_until_full();
    t_full_drop();
    t_underrun();
    t_clean_after();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule